// File: doc/BRIEF.md
# Reset Initialization Sequencer

This block turns three active-low reset sources (power-on, hard and soft) into a pair of stretched reset outputs for the rest of a processor-style device. Each source is filtered, so a short glitch never starts a flow. A qualified hard request pulls both outputs low for a fixed stretch. The hard output is released first, and the soft output follows a fixed number of cycles later. A soft-only request stretches just the soft output.

A qualified power-on reset has top priority. It aborts whatever flow is running and holds both outputs low for as long as it stays asserted. When it is released, the block latches the configuration straps (a reset-source field and a clock-divide select) and then runs the full stretched sequence, timed from the release. The strap sampler also checks that the straps were stable over a setup window just before release, and it raises a sticky error flag if they were not. Both reset outputs are open-drain pull enables: a 1 means pull the line low, and a 0 means let it float. The block never drives a line high.

Top module: `rst_seq_top`

## Requirements
- R1: A hard or soft request that is sampled low on fewer than FILT_LEN (32) consecutive clock edges is ignored. A request sampled low on FILT_LEN consecutive edges starts a flow, and the outputs are pulled from the edge FILT_LEN+1 onward, counted from the first low sample.
- R2: A hard flow pulls both outputs for exactly HOLD_LEN (512) cycles. It then releases the hard output and releases the soft output exactly GAP_LEN (16) cycles later.
- R3: A soft-only flow pulls the soft output for exactly HOLD_LEN cycles, and the hard output stays released throughout. When hard and soft qualify on the same edge, the hard flow wins.
- R4: The outputs are open-drain enables (1 = pull low, 0 = release). The hard output is never pulled while the soft output is released.
- R5: busy_o is 1 from the first cycle of a flow until the soft output is released. Hard or soft requests that qualify while busy_o is 1 are dropped. A request that is held low does not start a second flow.
- R6: A power-on input sampled low on FILT_LEN consecutive edges pulls both outputs and sets busy_o within one more cycle. A shorter power-on pulse has no effect on the outputs, on busy_o or on the latched straps.
- R7: A qualified power-on reset aborts any flow that is running. From the edge that first samples the power-on input high, the full R2 sequence runs again: hard is pulled for HOLD_LEN cycles, then the GAP_LEN gap follows.
- R8: On the edge that first samples the power-on input high after a qualified power-on reset, strap_src_o and strap_div_o take the values of strap_src_i and strap_div_i. At all other times they hold their value, including across hard and soft flows.
- R9: If the strap value sampled on the release edge differs from the value sampled on any of the SETUP_LEN (4) edges just before it, strap_err_o is set. It stays at 1 until rst_ni. A change first sampled SETUP_LEN edges before release is accepted.
- R10: While rst_ni is low, both outputs are released, busy_o is 0, the latched straps are 0 and strap_err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous block reset, active low |
| por_ni | input | 1 | Power-on reset request, active low |
| hard_req_ni | input | 1 | Hard reset request, active low |
| soft_req_ni | input | 1 | Soft reset request, active low |
| strap_src_i | input | SRC_W | Reset-source configuration strap |
| strap_div_i | input | 1 | Clock-divide configuration strap |
| hard_pull_o | output | 1 | Pull enable for the open-drain hard reset line |
| soft_pull_o | output | 1 | Pull enable for the open-drain soft reset line |
| strap_src_o | output | SRC_W | Latched reset-source strap |
| strap_div_o | output | 1 | Latched clock-divide strap |
| strap_err_o | output | 1 | Sticky strap setup violation |
| busy_o | output | 1 | Sequence in progress |

## Verification
Every request and release passes through a filter register and then the state register. A request first sampled low on edge 1 shows on the outputs after edge FILT_LEN+1, and the bench checks after edge FILT_LEN that nothing has started yet. The latched straps and the error flag follow the release edge after one register. The hard and soft releases are checked one cycle before and one cycle after their due edges, HOLD_LEN and HOLD_LEN+GAP_LEN after the start. Inputs are driven and outputs sampled on the falling clock edge, and each wait is counted in falling edges from the driving edge, so every check lands on a known cycle.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE = 3'd0,
    SEQ_POR  = 3'd1,
    SEQ_BOTH = 3'd2,
    SEQ_GAP  = 3'd3,
    SEQ_SOFT = 3'd4
  } seq_state_e;

  localparam int unsigned SRC_POR  = 0;
  localparam int unsigned SRC_HARD = 1;
  localparam int unsigned SRC_SOFT = 2;
  localparam int unsigned NUM_SRC  = 3;
endpackage

// File: rtl/rst_req_filter.sv
module rst_req_filter #(
  parameter int unsigned LEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;
  logic          fire_q;

  // saturating low-time counter; fire once on reaching LEN
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= !req_ni && (cnt_q == CW'(LEN - 1));
      if (req_ni)                 cnt_q <= '0;
      else if (cnt_q != CW'(LEN)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fire_o = fire_q;
endmodule

// File: rtl/rst_strap_cap.sv
module rst_strap_cap #(
  parameter int unsigned W     = 4,
  parameter int unsigned SETUP = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] strap_i,
  input  logic         cap_i,
  output logic [W-1:0] strap_o,
  output logic         err_o
);
  logic [W-1:0] hist_q [SETUP];
  logic [W-1:0] strap_q;
  logic         err_q;
  logic         stable;

  always_comb begin
    stable = 1'b1;
    for (int i = 0; i < int'(SETUP); i++) begin
      if (hist_q[i] != strap_i) stable = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(SETUP); i++) hist_q[i] <= '0;
    end else begin
      hist_q[0] <= strap_i;
      for (int i = 1; i < int'(SETUP); i++) hist_q[i] <= hist_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q <= '0;
      err_q   <= 1'b0;
    end else if (cap_i) begin
      strap_q <= strap_i;
      if (!stable) err_q <= 1'b1;
    end
  end

  assign strap_o = strap_q;
  assign err_o   = err_q;
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int unsigned HOLD_LEN = 512,
  parameter int unsigned GAP_LEN  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_ni,
  input  logic por_fire_i,
  input  logic hard_fire_i,
  input  logic soft_fire_i,
  output logic hard_pull_o,
  output logic soft_pull_o,
  output logic busy_o,
  output logic cap_o
);
  localparam int unsigned MAX_LEN = (HOLD_LEN > GAP_LEN) ? HOLD_LEN : GAP_LEN;
  localparam int unsigned CW      = $clog2(MAX_LEN + 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hold_done, gap_done;

  assign hold_done = (cnt_q == CW'(HOLD_LEN - 1));
  assign gap_done  = (cnt_q == CW'(GAP_LEN - 1));
  assign cap_o     = (state_q == SEQ_POR) && por_ni;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    if (por_fire_i) begin
      state_d = SEQ_POR;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          cnt_d = '0;
          if (hard_fire_i)      state_d = SEQ_BOTH;
          else if (soft_fire_i) state_d = SEQ_SOFT;
        end
        SEQ_POR: begin
          cnt_d = '0;
          if (por_ni) state_d = SEQ_BOTH;
        end
        SEQ_BOTH: if (hold_done) begin
          state_d = SEQ_GAP;
          cnt_d   = '0;
        end
        SEQ_GAP: if (gap_done) begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
        end
        SEQ_SOFT: if (hold_done) begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
        end
        default: begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign hard_pull_o = (state_q == SEQ_POR) || (state_q == SEQ_BOTH);
  assign soft_pull_o = hard_pull_o || (state_q == SEQ_GAP) || (state_q == SEQ_SOFT);
  assign busy_o      = (state_q != SEQ_IDLE);
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int unsigned FILT_LEN  = 32,
  parameter int unsigned HOLD_LEN  = 512,
  parameter int unsigned GAP_LEN   = 16,
  parameter int unsigned SETUP_LEN = 4,
  parameter int unsigned SRC_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             hard_req_ni,
  input  logic             soft_req_ni,
  input  logic [SRC_W-1:0] strap_src_i,
  input  logic             strap_div_i,
  output logic             hard_pull_o,
  output logic             soft_pull_o,
  output logic [SRC_W-1:0] strap_src_o,
  output logic             strap_div_o,
  output logic             strap_err_o,
  output logic             busy_o
);
  localparam int unsigned STRAP_W = SRC_W + 1;

  logic [NUM_SRC-1:0] req_n, fire;
  logic [STRAP_W-1:0] strap_in, strap_lat;
  logic               cap;

  assign req_n[SRC_POR]  = por_ni;
  assign req_n[SRC_HARD] = hard_req_ni;
  assign req_n[SRC_SOFT] = soft_req_ni;

  for (genvar g = 0; g < int'(NUM_SRC); g++) begin : g_filt
    rst_req_filter #(.LEN(FILT_LEN)) filt_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_ni (req_n[g]),
      .fire_o (fire[g])
    );
  end

  rst_seq_fsm #(.HOLD_LEN(HOLD_LEN), .GAP_LEN(GAP_LEN)) fsm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .por_ni      (por_ni),
    .por_fire_i  (fire[SRC_POR]),
    .hard_fire_i (fire[SRC_HARD]),
    .soft_fire_i (fire[SRC_SOFT]),
    .hard_pull_o (hard_pull_o),
    .soft_pull_o (soft_pull_o),
    .busy_o      (busy_o),
    .cap_o       (cap)
  );

  assign strap_in = {strap_div_i, strap_src_i};

  rst_strap_cap #(.W(STRAP_W), .SETUP(SETUP_LEN)) cap_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strap_i (strap_in),
    .cap_i   (cap),
    .strap_o (strap_lat),
    .err_o   (strap_err_o)
  );

  assign strap_div_o = strap_lat[STRAP_W-1];
  assign strap_src_o = strap_lat[SRC_W-1:0];
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int unsigned HOLD_LEN = 512,
  parameter int unsigned GAP_LEN  = 16,
  parameter int unsigned SRC_W    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             por_ni,
  input logic             hard_pull_o,
  input logic             soft_pull_o,
  input logic             busy_o,
  input logic [SRC_W-1:0] strap_src_o,
  input logic             strap_div_o,
  input logic             strap_err_o
);
  localparam int unsigned CW = $clog2(HOLD_LEN + 1);

  logic [CW-1:0] hard_run_q, soft_run_q, gap_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hard_run_q <= '0;
      soft_run_q <= '0;
      gap_run_q  <= '0;
    end else begin
      hard_run_q <= !hard_pull_o ? '0 : (hard_run_q == CW'(HOLD_LEN)) ? hard_run_q : hard_run_q + 1'b1;
      soft_run_q <= !soft_pull_o ? '0 : (soft_run_q == CW'(HOLD_LEN)) ? soft_run_q : soft_run_q + 1'b1;
      gap_run_q  <= !(soft_pull_o && !hard_pull_o) ? '0 :
                    (gap_run_q == CW'(GAP_LEN)) ? gap_run_q : gap_run_q + 1'b1;
    end
  end

  // R2
  hard_hold_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hard_pull_o) |-> (hard_run_q == CW'(HOLD_LEN)));

  // R2
  release_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(soft_pull_o) |-> (gap_run_q == CW'(GAP_LEN)));

  // R3
  soft_hold_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(soft_pull_o) |-> (soft_run_q == CW'(HOLD_LEN)));

  // R4
  hard_needs_soft_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_pull_o |-> soft_pull_o);

  // R5
  busy_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == soft_pull_o);

  // R8
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({strap_div_o, strap_src_o}) |-> ($past(por_ni) && $past(busy_o)));

  // R9
  strap_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_err_o |=> strap_err_o);
endmodule

bind rst_seq_top rst_seq_chk #(
  .HOLD_LEN (HOLD_LEN),
  .GAP_LEN  (GAP_LEN),
  .SRC_W    (SRC_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .por_ni      (por_ni),
  .hard_pull_o (hard_pull_o),
  .soft_pull_o (soft_pull_o),
  .busy_o      (busy_o),
  .strap_src_o (strap_src_o),
  .strap_div_o (strap_div_o),
  .strap_err_o (strap_err_o)
);

// File: tb/rst_seq_top_tb_top.sv
`timescale 1ns/1ps
module rst_seq_top_tb_top;
  localparam int L = 32;
  localparam int H = 512;
  localparam int G = 16;
  localparam int S = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_n = 1'b1, hard_n = 1'b1, soft_n = 1'b1;
  logic [2:0] src_in = 3'd0;
  logic       div_in = 1'b0;
  logic       hard_pull, soft_pull, err, busy, div_q;
  logic [2:0] src_q;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rst_seq_top #(.FILT_LEN(L), .HOLD_LEN(H), .GAP_LEN(G), .SETUP_LEN(S), .SRC_W(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .hard_req_ni(hard_n), .soft_req_ni(soft_n),
    .strap_src_i(src_in), .strap_div_i(div_in),
    .hard_pull_o(hard_pull), .soft_pull_o(soft_pull),
    .strap_src_o(src_q), .strap_div_o(div_q), .strap_err_o(err), .busy_o(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int outs();
    return {29'd0, hard_pull, soft_pull, busy};
  endfunction

  // expected {hard,soft,busy} code for a given phase
  function automatic int exp_outs(input bit h, input bit s);
    return {29'd0, h, s, s};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // request held low from a falling edge; flow visible after edge L+1
  task automatic req_flow(input bit hard_sel, input bit hold_on);
    if (hard_sel) hard_n = 1'b0; else soft_n = 1'b0;
    wait_n(L);
    chk("R1 not yet started", outs(), 0);
    wait_n(1);
    chk(hard_sel ? "R2 both pulled" : "R3 soft only pulled", outs(), exp_outs(hard_sel, 1'b1));
    if (!hold_on) begin hard_n = 1'b1; soft_n = 1'b1; end
    wait_n(H - 1);
    chk(hard_sel ? "R2 hold end-1" : "R3 hold end-1", outs(), exp_outs(hard_sel, 1'b1));
    wait_n(1);
    if (hard_sel) begin
      chk("R2 hard released, soft held", outs(), exp_outs(1'b0, 1'b1));
      wait_n(G - 1);
      chk("R2 gap end-1", outs(), exp_outs(1'b0, 1'b1));
      wait_n(1);
      chk("R2 soft released after gap", outs(), 0);
    end else begin
      chk("R3 soft released", outs(), 0);
    end
  endtask

  // qualified power-on; straps switch to s1 k edges before release
  task automatic por_flow(input logic [3:0] s0, input logic [3:0] s1, input int k,
                          input bit exp_err, input bit from_idle);
    logic [3:0] prev = {div_q, src_q};
    {div_in, src_in} = s0;
    por_n = 1'b0;
    wait_n(L);
    if (from_idle) chk("R6 por not yet valid", outs(), 0);
    wait_n(1);
    chk("R6 por pulls both", outs(), exp_outs(1'b1, 1'b1));
    chk("R8 straps held during por", {div_q, src_q}, prev);
    wait_n(20 - k);
    {div_in, src_in} = s1;
    wait_n(k);
    por_n = 1'b1;
    wait_n(1);
    chk("R8 straps captured", {div_q, src_q}, s1);
    chk("R9 strap error flag", err, exp_err);
    chk("R7 restart both pulled", outs(), exp_outs(1'b1, 1'b1));
    wait_n(H - 1);
    chk("R7 hold timed from release", outs(), exp_outs(1'b1, 1'b1));
    wait_n(1);
    chk("R7 hard released", outs(), exp_outs(1'b0, 1'b1));
    wait_n(G);
    chk("R7 soft released", outs(), 0);
  endtask

  initial begin
    logic [3:0] lat;
    void'($urandom(32'd1234));
    wait_n(3);
    chk("R10 reset outputs", outs(), 0);
    chk("R10 reset straps", {err, div_q, src_q}, 0);
    rst_n = 1'b1;
    wait_n(2);

    por_flow(4'hA, 4'hA, 0, 1'b0, 1'b1);
    req_flow(1'b1, 1'b0);
    chk("R8 straps kept after hard flow", {div_q, src_q}, 4'hA);
    req_flow(1'b0, 1'b0);

    // R1: random short glitches
    for (int i = 0; i < 24; i++) begin
      bit sel = 1'($urandom % 2);
      int n = $urandom_range(1, L - 1);
      if (sel) hard_n = 1'b0; else soft_n = 1'b0;
      wait_n(n);
      hard_n = 1'b1; soft_n = 1'b1;
      wait_n($urandom_range(1, 6));
    end
    wait_n(L + 4);
    chk("R1 random short pulses ignored", outs(), 0);

    // R1 boundary: L-1 low samples
    hard_n = 1'b0; wait_n(L - 1); hard_n = 1'b1; wait_n(L + 4);
    chk("R1 pulse of L-1 ignored", outs(), 0);

    // R3: both qualify on the same edge, hard wins
    soft_n = 1'b0;
    req_flow(1'b1, 1'b0);

    // R5: hard held and a soft request during busy
    hard_n = 1'b0;
    wait_n(L + 1);
    chk("R5 busy set", busy, 1);
    soft_n = 1'b0;
    wait_n(60);
    soft_n = 1'b1;
    wait_n(H + G - 60);
    chk("R5 busy clear at end", outs(), 0);
    wait_n(L + 20);
    chk("R5 held and busy-time requests ignored", outs(), 0);
    hard_n = 1'b1;
    wait_n(2);

    // R6: short power-on pulse
    lat = {div_q, src_q};
    {div_in, src_in} = 4'h5;
    por_n = 1'b0; wait_n(L - 1); por_n = 1'b1; wait_n(L + 4);
    chk("R6 short por ignored", outs(), 0);
    chk("R6 short por keeps straps", {div_q, src_q}, lat);

    // R9 setup window boundaries
    por_flow(4'h3, 4'hC, S, 1'b0, 1'b1);
    por_flow(4'h6, 4'h9, S - 1, 1'b1, 1'b1);
    por_flow(4'h2, 4'h2, 0, 1'b1, 1'b1);

    // R7: abort a running hard flow
    hard_n = 1'b0;
    wait_n(L + 1);
    hard_n = 1'b1;
    wait_n(200);
    por_flow(4'h7, 4'h7, 0, 1'b1, 1'b0);

    // R10: block reset clears sticky flag and straps
    rst_n = 1'b0;
    wait_n(2);
    chk("R10 reset clears flag and straps", {err, div_q, src_q}, 0);
    rst_n = 1'b1;
    wait_n(2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule